// File: doc/BRIEF.md
# Smart card event-driven timeout timer channel

This block is a single timer channel for a smart card host interface. It measures time in clock cycles against the stream of character START bits that the serial receive and transmit logic reports as one-cycle pulses. Software programs a 4-bit mode code, a reload value and an enable bit. In the down-counting modes the channel raises a sticky timeout flag when the programmed interval runs out before the next START bit. In the measuring mode it counts up for as long as the enable stays high and stores the result when the enable is cleared.

The counter width is a parameter: 24 bits for the first channel of an interface and 8 bits for the others. Four mode codes are recognised. 4'b0110 waits for a START bit, times out once, reloads and waits again. 4'b0111 starts at the first START bit and is retriggered by every later one. 4'b1111 behaves like 4'b0111 but also starts as soon as it is enabled. 4'b1000 measures elapsed enable time. A live-reload control selects whether a reload takes the current reload input or the value held when the channel was enabled.

Top module: `scard_tmr_chan`

## Requirements
- R1: While reset is asserted, and after reset until the first enable, the timeout flag reads 0 and the capture register reads 0.
- R2: In the down modes a count begins with the counter loaded with the reload value R. The timeout flag is set R+1 clock cycles after the edge that began the count and is still 0 one cycle earlier.
- R3: Mode 4'b0110 arms on enable and starts counting at a START pulse. After a timeout it reloads and waits, and it counts again only at the next START pulse.
- R4: Mode 4'b0111 starts counting at the first START pulse after enable. Each later START pulse reloads and restarts the count. After a timeout the counter stops until the next START pulse.
- R5: Mode 4'b1111 begins counting on the edge at which enable is first sampled high, with no START pulse needed. START pulses reload it as in R4.
- R6: A START pulse in the same cycle as the zero count reloads the counter and raises no timeout.
- R7: Mode 4'b1000 counts up from 0 beginning on the edge at which enable is first sampled high, and it ignores the reload value. When enable is cleared after being high for N edges, the capture register holds N-1. The count saturates at all ones. This mode never sets the timeout flag.
- R8: When live reload is 1, every reload uses the reload input as it stands at that edge. When live reload is 0, every reload uses the value the reload input had on the enabling edge.
- R9: Clearing enable returns the channel to idle on the next edge, and no timeout follows. START pulses while disabled are ignored.
- R10: The timeout flag stays set until a clear pulse. A clear pulse does not disturb a running count. A timeout in the same cycle as a clear leaves the flag set.
- R11: The mode code is taken on the enabling edge, and later changes have no effect until the channel is re-enabled. Unsupported codes leave the channel idle, with no timeout and no change to the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_en | input | 1 | Software enable for the channel |
| tmr_mode | input | 4 | Operating mode code |
| reload_val | input | W | Reload value R |
| live_reload | input | 1 | 1: reloads use the current reload input; 0: reloads use the value held at enable |
| start_evt | input | 1 | One-cycle pulse for each detected START bit |
| flag_clr | input | 1 | Write-one pulse that clears the timeout flag |
| tmo_flag | output | 1 | Sticky timeout interrupt status |
| capture | output | W | Measurement stored by mode 4'b1000 |

## Verification
On every cycle the assertions check the counter's step behaviour: the decrement in the down state, the increment in the measuring state, and the reload taken on a START pulse. They also check the flag's set, hold and clear rules, the return to idle when enable falls, and that the capture register changes only when a measurement ends. The timing from the start of a count to the timeout, the differences between the modes in what begins and ends a count, the choice between held and live reload values, and the handling of unsupported or changed mode codes are shown only by the bench's scenarios. Those scenarios sweep reload values and measurement lengths on an 8-bit channel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_WAIT = 2'd1,
    TS_DOWN = 2'd2,
    TS_UP   = 2'd3
  } tmr_state_e;

  typedef enum logic [2:0] {
    CC_HOLD = 3'd0,
    CC_LOAD = 3'd1,
    CC_DEC  = 3'd2,
    CC_CLR  = 3'd3,
    CC_INC  = 3'd4
  } cnt_cmd_e;

  localparam logic [3:0] MODE_REARM   = 4'b0110;
  localparam logic [3:0] MODE_RETRIG  = 4'b0111;
  localparam logic [3:0] MODE_MEASURE = 4'b1000;
  localparam logic [3:0] MODE_FREERUN = 4'b1111;

  function automatic logic mode_ok(input logic [3:0] m);
    return (m == MODE_REARM) || (m == MODE_RETRIG) ||
           (m == MODE_MEASURE) || (m == MODE_FREERUN);
  endfunction

endpackage

// File: rtl/tmr_seq.sv
module tmr_seq
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [3:0]  mode,
  input  logic        start,
  input  logic        cnt_zero,
  output tmr_state_e  state,
  output cnt_cmd_e    cmd,
  output logic        arm,
  output logic        expire,
  output logic        cap_en
);

  tmr_state_e state_q, state_d;
  logic [3:0] mode_q, mode_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cmd     = CC_HOLD;
    arm     = 1'b0;
    expire  = 1'b0;
    cap_en  = 1'b0;
    case (state_q)
      TS_IDLE: begin
        if (en && mode_ok(mode)) begin
          arm    = 1'b1;
          mode_d = mode;
          if (mode == MODE_MEASURE) begin
            state_d = TS_UP;
            cmd     = CC_CLR;
          end else if ((mode == MODE_FREERUN) || start) begin
            state_d = TS_DOWN;
            cmd     = CC_LOAD;
          end else begin
            state_d = TS_WAIT;
          end
        end
      end
      TS_WAIT: begin
        if (!en) begin
          state_d = TS_IDLE;
        end else if (start) begin
          state_d = TS_DOWN;
          cmd     = CC_LOAD;
        end
      end
      TS_DOWN: begin
        if (!en) begin
          state_d = TS_IDLE;
        end else if (start) begin
          cmd = CC_LOAD;
        end else if (cnt_zero) begin
          expire  = 1'b1;
          state_d = TS_WAIT;
          cmd     = (mode_q == MODE_REARM) ? CC_LOAD : CC_HOLD;
        end else begin
          cmd = CC_DEC;
        end
      end
      TS_UP: begin
        if (!en) begin
          state_d = TS_IDLE;
          cap_en  = 1'b1;
        end else begin
          cmd = CC_INC;
        end
      end
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      mode_q  <= 4'd0;
    end else begin
      state_q <= state_d;
      if (arm) mode_q <= mode_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/tmr_reload.sv
module tmr_reload #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         live,
  input  logic [W-1:0] reload_in,
  output logic [W-1:0] load_val
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (arm) held_q <= reload_in;
  end

  assign load_val = (live || arm) ? reload_in : held_q;

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_cmd_e     cmd,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         cnt_zero
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = (cmd != CC_HOLD);
    case (cmd)
      CC_LOAD: cnt_d = load_val;
      CC_DEC:  cnt_d = cnt_q - 1'b1;
      CC_CLR:  cnt_d = '0;
      CC_INC:  cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_d, flag_ce;

  always_comb begin
    flag_ce = set | clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/scard_tmr_chan.sv
module scard_tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  logic [3:0]   tmr_mode,
  input  logic [W-1:0] reload_val,
  input  logic         live_reload,
  input  logic         start_evt,
  input  logic         flag_clr,
  output logic         tmo_flag,
  output logic [W-1:0] capture
);

  logic [1:0]   rst_pipe;
  logic         rst_q;
  tmr_state_e   state;
  cnt_cmd_e     cmd;
  logic         arm, expire, cap_en, cnt_zero;
  logic [W-1:0] load_val, cnt;
  logic [W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  tmr_seq u_seq (
    .clk(clk), .rst_n(rst_q), .en(tmr_en), .mode(tmr_mode),
    .start(start_evt), .cnt_zero(cnt_zero), .state(state), .cmd(cmd),
    .arm(arm), .expire(expire), .cap_en(cap_en)
  );

  tmr_reload #(.W(W)) u_rld (
    .clk(clk), .rst_n(rst_q), .arm(arm), .live(live_reload),
    .reload_in(reload_val), .load_val(load_val)
  );

  tmr_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_q), .cmd(cmd), .load_val(load_val),
    .cnt(cnt), .cnt_zero(cnt_zero)
  );

  tmr_flag u_flag (
    .clk(clk), .rst_n(rst_q), .set(expire), .clr(flag_clr), .flag(tmo_flag)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cap_q <= '0;
    else if (cap_en) cap_q <= cnt;
  end
  assign capture = cap_q;

endmodule

// File: rtl/scard_tmr_chan_chk.sv
module scard_tmr_chan_chk
  import tmr_pkg::*;
#(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         start,
  input logic         clr,
  input logic         tmo_flag,
  input logic [W-1:0] capture,
  input tmr_state_e   state,
  input logic [W-1:0] cnt,
  input logic [W-1:0] load_val,
  input logic         expire,
  input logic         cap_en
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  a_r9_idle_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state == TS_IDLE);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr) |=> tmo_flag);

  a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !tmo_flag);

  a_r2_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmo_flag);

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_DOWN && en && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r6_start_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_DOWN && en && start) |=>
      (cnt == $past(load_val) && state == TS_DOWN && !$rose(tmo_flag)));

  a_r7_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_UP && en) |=>
      ((cnt == $past(cnt) + 1'b1) || ($past(cnt) == CMAX && cnt == CMAX)));

  a_r7_no_expire_up: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_UP) |-> !expire);

  a_r7_capture_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> capture == $past(cnt));

  a_r11_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(capture));

endmodule

bind scard_tmr_chan scard_tmr_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_q), .en(tmr_en), .start(start_evt), .clr(flag_clr),
  .tmo_flag(tmo_flag), .capture(capture), .state(state), .cnt(cnt),
  .load_val(load_val), .expire(expire), .cap_en(cap_en)
);

// File: tb/sim_scard_tmr_chan.sv
module sim_scard_tmr_chan;

  localparam int W = 8;

  logic         clk;
  logic         rst_n, tmr_en, live_reload, start_evt, flag_clr;
  logic [3:0]   tmr_mode;
  logic [W-1:0] reload_val;
  logic         tmo_flag;
  logic [W-1:0] capture;

  int n_chk;
  int n_fail;

  scard_tmr_chan #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tmr_mode(tmr_mode),
    .reload_val(reload_val), .live_reload(live_reload), .start_evt(start_evt),
    .flag_clr(flag_clr), .tmo_flag(tmo_flag), .capture(capture)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_evt = 1'b1;
    step(1);
    start_evt = 1'b0;
  endtask

  task automatic clear_all();
    tmr_en   = 1'b0;
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    step(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; tmr_en = 1'b0; live_reload = 1'b1; start_evt = 1'b0;
    flag_clr = 1'b0; tmr_mode = 4'b0000; reload_val = '0;
    step(3);
    chk("R1 flag in reset", int'(tmo_flag), 0);
    chk("R1 capture in reset", int'(capture), 0);
    rst_n = 1'b1;
    step(4);
    chk("R1 flag after reset", int'(tmo_flag), 0);
    chk("R1 capture after reset", int'(capture), 0);

    // R2 R3: rearm mode sweep
    for (int r = 0; r < 16; r++) begin
      tmr_mode = 4'b0110; reload_val = W'(r); tmr_en = 1'b1;
      step(3);
      chk("R3 armed no flag", int'(tmo_flag), 0);
      pulse_start();
      step(r);
      chk("R2 0110 early", int'(tmo_flag), 0);
      step(1);
      chk("R2 0110 timeout", int'(tmo_flag), 1);
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
      step(r + 5);
      chk("R3 waits for START", int'(tmo_flag), 0);
      pulse_start();
      step(r);
      chk("R3 second early", int'(tmo_flag), 0);
      step(1);
      chk("R3 second timeout", int'(tmo_flag), 1);
      clear_all();
    end

    // R2 R4: retrigger mode sweep
    for (int r = 0; r < 16; r++) begin
      tmr_mode = 4'b0111; reload_val = W'(r); tmr_en = 1'b1;
      step(2);
      pulse_start();
      step(r);
      chk("R4 0111 early", int'(tmo_flag), 0);
      step(1);
      chk("R4 0111 timeout", int'(tmo_flag), 1);
      clear_all();
    end

    // R5: free-running mode starts on enable
    for (int r = 0; r < 16; r++) begin
      tmr_mode = 4'b1111; reload_val = W'(r); tmr_en = 1'b1;
      step(1);
      step(r);
      chk("R5 1111 early", int'(tmo_flag), 0);
      step(1);
      chk("R5 1111 timeout", int'(tmo_flag), 1);
      clear_all();
    end

    // R4: retrigger restarts the count and stops after timeout
    tmr_mode = 4'b0111; reload_val = 8'd8; tmr_en = 1'b1;
    step(1);
    pulse_start();
    step(3);
    pulse_start();
    step(8);
    chk("R4 retrigger delays timeout", int'(tmo_flag), 0);
    step(1);
    chk("R4 retrigger timeout", int'(tmo_flag), 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    step(30);
    chk("R4 halted after timeout", int'(tmo_flag), 0);
    pulse_start();
    step(9);
    chk("R4 restarted timeout", int'(tmo_flag), 1);
    clear_all();

    // R5: START reloads in 1111 mode
    tmr_mode = 4'b1111; reload_val = 8'd6; tmr_en = 1'b1;
    step(4);
    pulse_start();
    step(6);
    chk("R5 start reload early", int'(tmo_flag), 0);
    step(1);
    chk("R5 start reload timeout", int'(tmo_flag), 1);
    clear_all();

    // R6: START coinciding with zero
    tmr_mode = 4'b0111; reload_val = 8'd5; tmr_en = 1'b1;
    step(1);
    pulse_start();
    step(5);
    pulse_start();
    chk("R6 no flag on collision", int'(tmo_flag), 0);
    step(5);
    chk("R6 reload early", int'(tmo_flag), 0);
    step(1);
    chk("R6 reload timeout", int'(tmo_flag), 1);
    clear_all();

    // R7: measuring sweep
    for (int n = 1; n <= 20; n++) begin
      tmr_mode = 4'b1000; reload_val = 8'd77; tmr_en = 1'b1;
      step(n);
      tmr_en = 1'b0;
      step(1);
      chk("R7 capture value", int'(capture), n - 1);
      chk("R7 no flag", int'(tmo_flag), 0);
      step(2);
    end
    tmr_mode = 4'b1000; tmr_en = 1'b1;
    step(300);
    tmr_en = 1'b0;
    step(1);
    chk("R7 saturation", int'(capture), 255);
    step(2);

    // R8: held versus live reload
    live_reload = 1'b0;
    tmr_mode = 4'b0110; reload_val = 8'd4; tmr_en = 1'b1;
    step(1);
    reload_val = 8'd10;
    pulse_start();
    step(4);
    chk("R8 held early", int'(tmo_flag), 0);
    step(1);
    chk("R8 held timeout", int'(tmo_flag), 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    pulse_start();
    step(4);
    chk("R8 held rearm early", int'(tmo_flag), 0);
    step(1);
    chk("R8 held rearm timeout", int'(tmo_flag), 1);
    clear_all();
    live_reload = 1'b1;
    reload_val = 8'd4; tmr_en = 1'b1;
    step(1);
    reload_val = 8'd10;
    pulse_start();
    step(10);
    chk("R8 live early", int'(tmo_flag), 0);
    step(1);
    chk("R8 live timeout", int'(tmo_flag), 1);
    clear_all();

    // R9: disable stops count, START ignored while disabled
    tmr_mode = 4'b1111; reload_val = 8'd10; tmr_en = 1'b1;
    step(4);
    tmr_en = 1'b0;
    step(30);
    chk("R9 no timeout after disable", int'(tmo_flag), 0);
    pulse_start();
    step(30);
    chk("R9 START ignored", int'(tmo_flag), 0);

    // R10: sticky flag, clear during count, set beats clear
    tmr_mode = 4'b0110; reload_val = 8'd6; tmr_en = 1'b1;
    step(1);
    pulse_start();
    step(7);
    chk("R10 first timeout", int'(tmo_flag), 1);
    step(10);
    chk("R10 flag sticky", int'(tmo_flag), 1);
    pulse_start();
    step(2);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R10 cleared", int'(tmo_flag), 0);
    step(3);
    chk("R10 count undisturbed early", int'(tmo_flag), 0);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R10 set beats clear", int'(tmo_flag), 1);
    clear_all();

    // R11: unsupported mode and mode change mid-run
    tmr_mode = 4'b1000; tmr_en = 1'b1;
    step(3);
    tmr_mode = 4'b0110;
    step(4);
    tmr_en = 1'b0;
    step(1);
    chk("R11 mode held at enable", int'(capture), 6);
    tmr_mode = 4'b0011; reload_val = 8'd2; tmr_en = 1'b1;
    step(2);
    pulse_start();
    step(20);
    chk("R11 unsupported no flag", int'(tmo_flag), 0);
    tmr_en = 1'b0;
    step(2);
    chk("R11 unsupported capture kept", int'(capture), 6);

    finish_run();
  end

endmodule